// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block works out where a 64-bit processor goes after a conditional branch. It takes the 32-bit instruction word, the current instruction address, the count, condition and link registers and the width-mode flag. One clock later it presents three results: the next instruction address, the new count register and the new link register. It handles two branch forms. The first carries a 14-bit word displacement and can be relative or absolute. The second jumps to the address held in the link register.

A 5-bit control field in the instruction sets the branch condition. Its bits decide three things: whether the counter is decremented, which result of the counter-zero test lets the branch go, and which value of the selected condition bit lets it go. In 32-bit mode only the low half of the counter counts toward the zero test. Any word that is neither branch form passes through: it advances the address by 4 and leaves both registers unchanged.

Top module: `branch_resolve`

## Requirements
- R1: Results appear on the clock edge after the edge that samples `in_valid` high. `out_valid` is high for exactly those cycles. Synchronous active-high reset clears `out_valid`, `nia_out`, `ctr_out` and `lr_out` to zero. When `in_valid` is low, the data outputs hold their values.
- R2: The control field is bits [25:21] of the word. Its numbered bits run from the most significant end: c0=bit 25, c1=bit 24, c2=bit 23, c3=bit 22, c4=bit 21 (c4 is ignored). When c2=0, `ctr_out` is the count register minus one, wrapping modulo 2^64. When c2=1, the count register passes through unchanged.
- R3: The counter test passes when c2=1, or when (the updated counter is nonzero) XOR c3 is true.
- R4: When `mode64`=0, only bits [31:0] of the updated counter enter the nonzero test. When `mode64`=1, all 64 bits do.
- R5: The condition test passes when c0=1, or when the selected condition bit equals c1. The bit index BI is taken from bits [20:16] and counts from the most significant bit of `cr`, so the bit used is `cr[31-BI]`.
- R6: A branch is taken only when both tests pass. Otherwise `nia_out` is `cia`+4.
- R7: Displacement form: opcode bits [31:26]=6'b010000, displacement in bits [15:2], absolute flag in bit 1. The target is the sign-extended displacement with two zero bits appended. It is used as is when bit 1 is 1, and added to `cia` when bit 1 is 0.
- R8: Link-register form: opcode bits [31:26]=6'b010011 and bits [10:1]=10'd16. The target is `lr` with bits [1:0] forced to zero. It uses the `lr` value from before this instruction's own link update.
- R9: When link bit 0 is 1 in either branch form, `lr_out` is `cia`+4 whether or not the branch is taken. When it is 0, `lr_out` equals `lr`.
- R10: A word matching neither form gives `nia_out`=`cia`+4, `ctr_out`=`ctr` and `lr_out`=`lr`, whatever its other bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is present this cycle |
| instr | input | 32 | Instruction word |
| cia | input | 64 | Current instruction address |
| ctr | input | 64 | Count register |
| cr | input | 32 | Condition register |
| lr | input | 64 | Link register |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| out_valid | output | 1 | Results below belong to the previous cycle's instruction |
| nia_out | output | 64 | Next instruction address |
| ctr_out | output | 64 | Updated count register |
| lr_out | output | 64 | Updated link register |

## Verification
Every result goes through a single register stage, so `nia_out`, `ctr_out`, `lr_out` and `out_valid` are all due one clock after the input was sampled. The bench drives each instruction on a falling edge and lets one rising edge pass. It then compares all four outputs with its reference model on the next falling edge, once per clock, so none of the comparisons lands on the edge where the outputs change. During idle cycles the expected data values stay fixed, which checks that the outputs hold.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int OPW  = 6;
  localparam int BOW  = 5;
  localparam int BIW  = 5;
  localparam int BDW  = 14;
  localparam int XOW  = 10;

  localparam logic [OPW-1:0] OP_DISP = 6'b010000;
  localparam logic [OPW-1:0] OP_LINK = 6'b010011;
  localparam logic [XOW-1:0] XO_LINK = 10'd16;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_DISP = 2'd1,
    FORM_LINK = 2'd2
  } form_e;

  // ctl[3] = c0 (ignore cond), ctl[2] = c1 (wanted cond value),
  // ctl[1] = c2 (no decrement), ctl[0] = c3 (branch on zero)
  typedef struct packed {
    form_e            form;
    logic [3:0]       ctl;
    logic [BIW-1:0]   bi;
    logic [BDW-1:0]   bd;
    logic             aa;
    logic             lk;
  } br_fields_t;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int ILEN = 32
) (
  input  logic [ILEN-1:0] instr,
  output br_fields_t      fld
);

  localparam int OP_LO = ILEN - OPW;
  localparam int BO_LO = OP_LO - BOW;
  localparam int BI_LO = BO_LO - BIW;

  logic [OPW-1:0] op;
  logic [XOW-1:0] xo;
  logic           unused_hint;

  assign op          = instr[ILEN-1:OP_LO];
  assign xo          = instr[XOW:1];
  assign unused_hint = instr[BO_LO];

  always_comb begin
    fld.form = FORM_NONE;
    if (op == OP_DISP)
      fld.form = FORM_DISP;
    else if (op == OP_LINK && xo == XO_LINK)
      fld.form = FORM_LINK;
    fld.ctl = instr[OP_LO-1:BO_LO+1];
    fld.bi  = instr[BO_LO-1:BI_LO];
    fld.bd  = instr[BI_LO-1:2];
    fld.aa  = instr[1];
    fld.lk  = instr[0];
  end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CRW  = 32
) (
  input  logic [3:0]      ctl,
  input  logic [BIW-1:0]  bi,
  input  logic [CRW-1:0]  cr,
  input  logic [XLEN-1:0] ctr,
  input  logic            mode64,
  output logic [XLEN-1:0] ctr_upd,
  output logic            go
);

  localparam int HALF = XLEN / 2;

  logic           nonzero;
  logic           ctr_ok;
  logic           cond_ok;
  logic [BIW-1:0] idx;

  assign ctr_upd = ctl[1] ? ctr : ctr - XLEN'(1);
  assign nonzero = mode64 ? (|ctr_upd) : (|ctr_upd[HALF-1:0]);
  assign ctr_ok  = ctl[1] | (nonzero ^ ctl[0]);
  assign idx     = BIW'(CRW - 1) - bi;
  assign cond_ok = ctl[3] | (cr[idx] ~^ ctl[2]);
  assign go      = ctr_ok & cond_ok;

endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  form_e           form,
  input  logic [BDW-1:0]  bd,
  input  logic            aa,
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] lr,
  output logic [XLEN-1:0] tgt
);

  localparam int EXTW = XLEN - BDW - 2;
  localparam logic [XLEN-1:0] ALIGN_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};

  logic [XLEN-1:0] offs;

  assign offs = {{EXTW{bd[BDW-1]}}, bd, 2'b00};

  always_comb begin
    if (form == FORM_LINK)
      tgt = lr & ALIGN_MASK;
    else if (aa)
      tgt = offs;
    else
      tgt = cia + offs;
  end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import bru_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int ILEN = 32,
  parameter int CRW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] ctr,
  input  logic [CRW-1:0]  cr,
  input  logic [XLEN-1:0] lr,
  input  logic            mode64,
  output logic            out_valid,
  output logic [XLEN-1:0] nia_out,
  output logic [XLEN-1:0] ctr_out,
  output logic [XLEN-1:0] lr_out
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  br_fields_t      fld;
  logic [XLEN-1:0] ctr_upd;
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] seq_addr;
  logic            go;
  logic            is_br;

  bru_decode #(.ILEN(ILEN)) u_dec (
    .instr (instr),
    .fld   (fld)
  );

  bru_cond #(.XLEN(XLEN), .CRW(CRW)) u_cond (
    .ctl     (fld.ctl),
    .bi      (fld.bi),
    .cr      (cr),
    .ctr     (ctr),
    .mode64  (mode64),
    .ctr_upd (ctr_upd),
    .go      (go)
  );

  bru_target #(.XLEN(XLEN)) u_tgt (
    .form (fld.form),
    .bd   (fld.bd),
    .aa   (fld.aa),
    .cia  (cia),
    .lr   (lr),
    .tgt  (tgt)
  );

  assign seq_addr = cia + STEP;
  assign is_br    = (fld.form != FORM_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      nia_out   <= '0;
      ctr_out   <= '0;
      lr_out    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        nia_out <= (is_br && go) ? tgt : seq_addr;
        ctr_out <= is_br ? ctr_upd : ctr;
        lr_out  <= (is_br && fld.lk) ? seq_addr : lr;
      end
    end
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(nia_out) && $stable(lr_out));
  assert_ctr_keep_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_br && fld.ctl[1]) |=> ctr_out == $past(ctr));
  assert_fallthru_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(is_br && go)) |=> nia_out == $past(cia) + STEP);
  assert_lr_target_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fld.form == FORM_LINK && go) |=>
      nia_out == {$past(lr[XLEN-1:2]), 2'b00});
  assert_link_write_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_br && fld.lk) |=> lr_out == $past(cia) + STEP);
  assert_nonbranch_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_br) |=> ctr_out == $past(ctr) && lr_out == $past(lr));

endmodule

// File: tb/branch_resolve_test.sv
`timescale 1ns/1ps
module branch_resolve_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] cia = '0, ctr = '0, lr = '0;
  logic [31:0] cr = '0;
  logic        mode64 = 1'b1;
  logic        out_valid;
  logic [63:0] nia_out, ctr_out, lr_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        e_valid = 0;
  logic [63:0] e_nia = 0, e_ctr = 0, e_lr = 0;

  always #10 clk = ~clk;

  branch_resolve uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .cia(cia),
    .ctr(ctr), .cr(cr), .lr(lr), .mode64(mode64), .out_valid(out_valid),
    .nia_out(nia_out), .ctr_out(ctr_out), .lr_out(lr_out)
  );

  function automatic logic [31:0] mk_disp(logic [4:0] bo, logic [4:0] bi,
                                          logic [13:0] bd, logic aa, logic lk);
    return {6'b010000, bo, bi, bd, aa, lk};
  endfunction

  function automatic logic [31:0] mk_link(logic [4:0] bo, logic [4:0] bi, logic lk);
    return {6'b010011, bo, bi, 5'b00000, 10'd16, lk};
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model: computes the results expected one clock later
  task automatic model(logic v, logic [31:0] w, logic [63:0] a, logic [63:0] c,
                       logic [31:0] cond, logic [63:0] l, logic m);
    bit is_disp, is_link, c0, c1, c2, c3, nz, pass;
    logic [63:0] cnt, off, dest;
    int bi;
    e_valid = v;
    if (!v) return;
    is_disp = (w[31:26] == 6'd16);
    is_link = (w[31:26] == 6'd19) && (w[10:1] == 10'd16);
    if (!is_disp && !is_link) begin
      e_nia = a + 64'd4; e_ctr = c; e_lr = l;
      return;
    end
    c0 = w[25]; c1 = w[24]; c2 = w[23]; c3 = w[22];
    bi = int'(w[20:16]);
    cnt = c2 ? c : c - 64'd1;
    nz = m ? (cnt != 64'd0) : (cnt[31:0] != 32'd0);
    pass = (c2 || (nz != c3)) && (c0 || (cond[31-bi] == c1));
    off = 64'($signed({w[15:2], 2'b00}));
    if (is_link) dest = {l[63:2], 2'b00};
    else if (w[1]) dest = off;
    else dest = a + off;
    e_nia = pass ? dest : a + 64'd4;
    e_ctr = cnt;
    e_lr  = w[0] ? a + 64'd4 : l;
  endtask

  task automatic step(string tag, logic v, logic [31:0] w, logic [63:0] a,
                      logic [63:0] c, logic [31:0] cond, logic [63:0] l, logic m);
    in_valid = v; instr = w; cia = a; ctr = c; cr = cond; lr = l; mode64 = m;
    model(v, w, a, c, cond, l, m);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "out_valid", {63'd0, out_valid}, {63'd0, e_valid});
    chk(tag, "nia", nia_out, e_nia);
    chk(tag, "ctr", ctr_out, e_ctr);
    chk(tag, "lr", lr_out, e_lr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "reset valid", {63'd0, out_valid}, 64'd0);
    chk("R1", "reset nia", nia_out, 64'd0);
    chk("R1", "reset ctr", ctr_out, 64'd0);
    chk("R1", "reset lr", lr_out, 64'd0);

    // R7 relative taken, always-branch code (c0=1, c2=1)
    step("R7", 1, mk_disp(5'b10100, 5'd0, 14'd8, 0, 0), 64'h1000, 64'd5, 0, 64'h2000, 1);
    // R7 negative displacement
    step("R7", 1, mk_disp(5'b10100, 5'd0, 14'h3FFC, 0, 0), 64'h1000, 64'd5, 0, 64'h2000, 1);
    // R7 absolute
    step("R7", 1, mk_disp(5'b10100, 5'd0, 14'h0040, 1, 0), 64'h1000, 64'd5, 0, 64'h2000, 1);
    // R1 idle: outputs hold
    step("R1", 0, 32'hFFFF_FFFF, 64'h9, 64'h9, 0, 64'h9, 1);
    // R2 R3 decrement to zero, branch if nonzero -> not taken (R6)
    step("R3", 1, mk_disp(5'b10000, 5'd0, 14'd16, 0, 0), 64'h3000, 64'd1, 0, 64'h0, 1);
    step("R3", 1, mk_disp(5'b10000, 5'd0, 14'd16, 0, 0), 64'h3000, 64'd2, 0, 64'h0, 1);
    // R3 branch if zero
    step("R3", 1, mk_disp(5'b10010, 5'd0, 14'd16, 0, 0), 64'h3000, 64'd1, 0, 64'h0, 1);
    // R2 wrap at zero
    step("R2", 1, mk_disp(5'b10000, 5'd0, 14'd16, 0, 0), 64'h3000, 64'd0, 0, 64'h0, 1);
    // R4 high half nonzero, low half zero after decrement
    step("R4", 1, mk_disp(5'b10000, 5'd0, 14'd16, 0, 0), 64'h3000, 64'h1_0000_0001, 0, 64'h0, 0);
    step("R4", 1, mk_disp(5'b10000, 5'd0, 14'd16, 0, 0), 64'h3000, 64'h1_0000_0001, 0, 64'h0, 1);
    // R5 condition bit BI=0 is cr[31]; BI=31 is cr[0]
    step("R5", 1, mk_disp(5'b01100, 5'd0, 14'd4, 0, 0), 64'h4000, 64'd7, 32'h8000_0000, 0, 1);
    step("R5", 1, mk_disp(5'b01100, 5'd0, 14'd4, 0, 0), 64'h4000, 64'd7, 32'h0000_0001, 0, 1);
    step("R5", 1, mk_disp(5'b00100, 5'd31, 14'd4, 0, 0), 64'h4000, 64'd7, 32'h0000_0000, 0, 1);
    step("R6", 1, mk_disp(5'b00100, 5'd31, 14'd4, 0, 0), 64'h4000, 64'd7, 32'h0000_0001, 0, 1);
    // R8 link-register form with LK: target is old lr, masked
    step("R8", 1, mk_link(5'b10100, 5'd0, 1), 64'h5000, 64'd3, 0, 64'h7777_0003, 1);
    step("R8", 1, mk_link(5'b10100, 5'd0, 0), 64'h5000, 64'd3, 0, 64'h0000_0abe, 1);
    // R9 link written when not taken
    step("R9", 1, mk_disp(5'b00100, 5'd3, 14'd4, 0, 1), 64'h6000, 64'd3, 32'h1000_0000, 64'h1234, 1);
    // R10 other opcodes / wrong extended code
    step("R10", 1, 32'h4000_0001 ^ 32'h0C00_0000, 64'h7000, 64'd9, 0, 64'h55, 1);
    step("R10", 1, {6'b010011, 5'b00000, 5'd0, 5'd0, 10'd17, 1'b1}, 64'h7000, 64'd9, 0, 64'h55, 1);

    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      int sel = int'($urandom_range(0, 3));
      case (sel)
        0: w = mk_disp(5'($urandom), 5'($urandom), 14'($urandom), 1'($urandom), 1'($urandom));
        1: w = mk_link(5'($urandom), 5'($urandom), 1'($urandom));
        2: w = $urandom;
        default: w = mk_disp(5'($urandom), 5'($urandom), 14'($urandom), 0, 0);
      endcase
      step("R6", 1'($urandom_range(0, 4) != 0), w,
           {$urandom, $urandom}, ($urandom_range(0, 2) == 0) ? 64'($urandom_range(0, 2)) : {$urandom, $urandom},
           $urandom, {$urandom, $urandom}, 1'($urandom));
    end

    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule